// File: doc/BRIEF.md
# Polyphonic Note-Driven Oscillator Bank

This block turns note messages from a processor into audio. A host writes packed note-on, note-off and tone-change messages, a master volume and a waveform choice through a small write-only register port. The block keeps a pool of phase-accumulator voices. A note-on claims an idle voice and a note-off releases it. Every sounding voice produces a sawtooth, square or triangle wave at its note's pitch.

A divider derived from the system clock makes one sample tick per output period (96 kHz by default). On each tick the block adds up the outputs of the sounding voices in a wider accumulator. It scales the sum by the master volume, clamps the result to 32-bit signed PCM and presents it with a one-cycle valid strobe. Pitch comes from a 12-entry semitone table for the top octave, which is shifted right once for each octave below it. Notes 21 (A0) to 108 (C8) are accepted.

Top module: `poly_osc_bank`

## Requirements
- R1: There are VOICES (default 16) voices. A note-on with velocity other than zero claims the lowest-numbered idle voice and restarts its phase at 0. When every voice is busy, a further note-on changes nothing.
- R2: A note-off, or a note-on with velocity 0, releases every busy voice that holds that note number. A note-off for a note that no voice holds changes nothing.
- R3: A note-on or note-off whose note number lies outside 21..108 changes no voice state.
- R4: The per-tick phase increment of note n is TOP[s] >> (7 - o), where s = (n-21) mod 12, o = (n-21) / 12, TOP[0] = 157482134 and the other TOP[s] scale by 2^(s/12). Note 69 gives 19685266, note 81 gives 39370533, note 108 gives 187278856 and note 21 gives 1230329.
- R5: For a 32-bit phase p, the waveforms are defined as follows. Sawtooth is p - 2^31. Square is +(2^31-1) while p[31]=0 and -(2^31-1) otherwise. Triangle is 2*t - 2^31, where t = p[30:0] while p[31]=0 and ~p[30:0] otherwise. Phase 0 therefore gives sawtooth 0x80000000, square 0x7FFFFFFF and triangle 0x80000000.
- R6: Register offset 2 (wr_addr=2) selects the waveform for all voices: 0 = sawtooth, 1 = square, 2 = triangle. The value 3 is ignored. A message with status high nibble 0xC sets the waveform from data1 when data1 is 0..2.
- R7: Each sample equals clamp((sum of sounding voice values * vol) >>> 7) to the 32-bit signed range. Here vol is the unsigned 8-bit value written at offset 1, so 128 is unity gain and 0 mutes. Idle voices contribute 0.
- R8: sample_valid is high for exactly one cycle every TICK_DIV clocks. sample_out changes only in a cycle where sample_valid is high. A voice started between two ticks contributes its phase-0 value to the next sample.
- R9: After reset, all voices are idle, the waveform is sawtooth, vol is 128, and sample_out and sample_valid are 0.
- R10: At offset 0 (wr_addr=0) a message is packed as status in wr_data[23:16], note in wr_data[15:8] and velocity in wr_data[7:0]. A status high nibble of 0x9 means note-on and 0x8 means note-off. The channel nibble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset: 0 message, 1 volume, 2 waveform |
| wr_data | input | 32 | Write data |
| sample_out | output | 32 | Mixed signed PCM sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench sets square waves and unit-scale volume so that the sample level counts the sounding voices. This exposes four kinds of fault: a full pool that still takes a seventeenth note, a release that hits the wrong voice, a velocity-0 note-on treated as a sounding note, and an out-of-range note that claims a voice. Pitch is measured as the step between consecutive sawtooth samples at both ends of the note range and across one octave. An error in the table or in the octave shift changes that step. Both clamp directions are driven with a large volume on several voices, where a design without saturation would wrap around to the opposite sign. The bench also writes the unused waveform code and checks that the output shape does not change.

// File: rtl/poly_osc_bank.sv
module poly_osc_bank #(
  parameter int VOICES    = 16,
  parameter int TICK_DIV  = 1042,
  parameter int VOL_W     = 8,
  parameter int VOL_SHIFT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] sample_out,
  output logic        sample_valid
);
  localparam int CW = $clog2(TICK_DIV);
  localparam int IW = $clog2(VOICES);
  localparam int SW = 32 + IW;
  localparam int PW = SW + VOL_W + 1;

  logic [CW-1:0]    cnt;
  logic             tick;
  logic [VOICES-1:0] active;
  logic [6:0]       vnote [VOICES];
  logic [31:0]      phase [VOICES];
  logic [31:0]      inc   [VOICES];
  logic [VOL_W-1:0] vol;
  logic [1:0]       wave;

  wire [3:0] kind  = wr_data[23:20];
  wire [7:0] d1    = wr_data[15:8];
  wire [7:0] d2    = wr_data[7:0];
  wire       msg   = wr_en && wr_addr == 2'd0;
  wire       ok    = d1 >= 8'd21 && d1 <= 8'd108;
  wire       n_on  = msg && ok && kind == 4'h9 && d2 != 8'd0;
  wire       n_off = msg && ok && (kind == 4'h8 || (kind == 4'h9 && d2 == 8'd0));

  assign tick = cnt == CW'(TICK_DIV - 1);

  function automatic logic [31:0] note_inc(input logic [7:0] n);
    logic [7:0] idx, oct, semi;
    logic [31:0] top;
    idx  = n - 8'd21;
    oct  = idx / 8'd12;
    semi = idx % 8'd12;
    case (semi)
      8'd0:    top = 32'd157482134;
      8'd1:    top = 32'd166846494;
      8'd2:    top = 32'd176767711;
      8'd3:    top = 32'd187278856;
      8'd4:    top = 32'd198415048;
      8'd5:    top = 32'd210213452;
      8'd6:    top = 32'd222713439;
      8'd7:    top = 32'd235956584;
      8'd8:    top = 32'd249987297;
      8'd9:    top = 32'd264852351;
      8'd10:   top = 32'd280601194;
      default: top = 32'd297286741;
    endcase
    return top >> (3'd7 - oct[2:0]);
  endfunction

  logic          have_free;
  logic [IW-1:0] free_idx;
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int v = VOICES - 1; v >= 0; v--)
      if (!active[v]) begin
        have_free = 1'b1;
        free_idx  = IW'(v);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= '0;
      for (int v = 0; v < VOICES; v++) begin
        vnote[v] <= '0;
        phase[v] <= '0;
        inc[v]   <= '0;
      end
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      for (int v = 0; v < VOICES; v++) begin
        if (tick && active[v]) phase[v] <= phase[v] + inc[v];
        if (n_off && active[v] && vnote[v] == d1[6:0]) active[v] <= 1'b0;
        if (n_on && have_free && free_idx == IW'(v)) begin
          active[v] <= 1'b1;
          vnote[v]  <= d1[6:0];
          inc[v]    <= note_inc(d1);
          phase[v]  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol  <= VOL_W'(1 << VOL_SHIFT);
      wave <= 2'd0;
    end else if (wr_en) begin
      if (wr_addr == 2'd1) vol <= wr_data[VOL_W-1:0];
      if (wr_addr == 2'd2 && wr_data[1:0] != 2'd3 && wr_data[31:2] == '0) wave <= wr_data[1:0];
      if (wr_addr == 2'd0 && kind == 4'hC && d1 < 8'd3) wave <= d1[1:0];
    end
  end

  logic signed [SW-1:0] sum;
  always_comb begin
    logic [31:0] p;
    logic [30:0] t;
    logic signed [31:0] w;
    sum = '0;
    for (int v = 0; v < VOICES; v++) begin
      p = phase[v];
      t = p[31] ? ~p[30:0] : p[30:0];
      case (wave)
        2'd0:    w = {~p[31], p[30:0]};
        2'd1:    w = p[31] ? 32'sh8000_0001 : 32'sh7FFF_FFFF;
        default: w = {~t[30], t[29:0], 1'b0};
      endcase
      if (active[v]) sum = sum + SW'(w);
    end
  end

  logic signed [PW-1:0] prod, scaled;
  assign prod   = sum * $signed({1'b0, vol});
  assign scaled = prod >>> VOL_SHIFT;
  wire in_rng   = (&scaled[PW-1:31]) || ~(|scaled[PW-1:31]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= tick;
      if (tick)
        sample_out <= in_rng ? scaled[31:0] : (scaled[PW-1] ? 32'h8000_0000 : 32'h7FFF_FFFF);
    end
  end
endmodule

module osc_bank_chk #(
  parameter int VOICES   = 16,
  parameter int TICK_DIV = 1042,
  parameter int VOL_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       sample_out,
  input logic              sample_valid,
  input logic              tick,
  input logic [VOICES-1:0] active,
  input logic [VOL_W-1:0]  vol
);
  logic [31:0] gap;
  logic        seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap  <= sample_valid ? 32'd1 : gap + 32'd1;
      if (sample_valid) seen <= 1'b1;
    end
  end

  wire bad_note = wr_data[15:8] < 8'd21 || wr_data[15:8] > 8'd108;
  wire note_msg = wr_en && wr_addr == 2'd0 && (wr_data[23:20] == 4'h9 || wr_data[23:20] == 4'h8);
  wire on_msg   = wr_en && wr_addr == 2'd0 && wr_data[23:20] == 4'h9 && wr_data[7:0] != 8'd0;

  AST_VALID_PERIOD:  assert property (@(posedge clk) disable iff (!rst_n) (sample_valid && seen) |-> gap == 32'(TICK_DIV)); // R8
  AST_OUT_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !sample_valid |-> $stable(sample_out)); // R8
  AST_IDLE_SILENT:   assert property (@(posedge clk) disable iff (!rst_n) (tick && active == '0) |=> sample_out == 32'd0); // R7
  AST_MUTE:          assert property (@(posedge clk) disable iff (!rst_n) (tick && vol == '0) |=> sample_out == 32'd0); // R7
  AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (note_msg && bad_note) |=> $stable(active)); // R3
  AST_FULL_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n) (on_msg && &active) |=> &active); // R1
endmodule

bind poly_osc_bank osc_bank_chk #(.VOICES(VOICES), .TICK_DIV(TICK_DIV), .VOL_W(VOL_W)) u_chk (.*);

// File: tb/test_poly_osc_bank.sv
module test_poly_osc_bank;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sample_out;
  logic        sample_valid;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  poly_osc_bank #(.TICK_DIV(8)) i_poly_osc_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_out(sample_out), .sample_valid(sample_valid));

  // {addr, data, expected sounding voices}; square wave, volume 1
  localparam int NV = 9;
  localparam logic [38:0] VEC [NV] = '{
    {2'd2, 32'h0000_0001, 5'd0},   // R6 square
    {2'd1, 32'h0000_0001, 5'd0},   // R7 volume 1
    {2'd0, 32'h0090_1540, 5'd1},   // R1 note 21 on
    {2'd0, 32'h0093_1640, 5'd2},   // R10 note 22 on, other channel
    {2'd0, 32'h0090_1440, 5'd2},   // R3 note 20 ignored
    {2'd0, 32'h0090_6D40, 5'd2},   // R3 note 109 ignored
    {2'd0, 32'h0080_1500, 5'd1},   // R2 note 21 off
    {2'd0, 32'h0090_1600, 5'd0},   // R2 velocity 0 = off
    {2'd0, 32'h0080_1E00, 5'd0}    // R2 unheld note off
  };

  function automatic logic [31:0] lvl(input int n);
    longint v;
    v = (longint'(n) * 64'sd2147483647) >>> 7;
    return v[31:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!sample_valid) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [1:0] a, input logic [31:0] d, output logic [31:0] s);
    wait_valid();
    wr(a, d);
    wait_valid();
    s = sample_out;
  endtask

  task automatic step_of(input logic [7:0] n, output logic [31:0] d);
    logic [31:0] s1;
    send(2'd0, {16'h0090, n, 8'h40}, s1);
    wait_valid();
    d = sample_out - s1;
    send(2'd0, {16'h0080, n, 8'h00}, s1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int gap;
    repeat (3) @(negedge clk);
    chk("R9 out after reset", sample_out, 32'd0);
    chk("R9 valid after reset", {31'd0, sample_valid}, 32'd0);
    rst_n = 1'b1;
    wait_valid();
    chk("R9 idle sample", sample_out, 32'd0);
    gap = 0;
    @(negedge clk); gap++;
    chk("R8 strobe width", {31'd0, sample_valid}, 32'd0);
    while (!sample_valid) begin @(negedge clk); gap++; end
    chk("R8 tick period", 32'(gap), 32'd8);

    send(2'd0, 32'h0090_4540, s);
    chk("R9 R5 default saw phase 0", s, 32'h8000_0000);
    wait_valid();
    chk("R4 note 69 step", sample_out - s, 32'd19685266);
    send(2'd0, 32'h0080_4500, s);
    step_of(8'd81, d); chk("R4 note 81 step", d, 32'd39370533);
    step_of(8'd108, d); chk("R4 note 108 step", d, 32'd187278856);
    step_of(8'd21, d); chk("R4 note 21 step", d, 32'd1230329);

    send(2'd0, 32'h00C0_0200, s);
    send(2'd0, 32'h0090_4540, s);
    chk("R6 R5 triangle phase 0", s, 32'h8000_0000);
    wait_valid();
    chk("R5 triangle rise", sample_out, 32'h8000_0000 + 32'd39370532);
    send(2'd0, 32'h0080_4500, s);
    send(2'd2, 32'h0000_0001, s);
    send(2'd0, 32'h0090_4540, s);
    chk("R5 square phase 0", s, 32'h7FFF_FFFF);
    send(2'd2, 32'h0000_0003, s);
    chk("R6 code 3 ignored", s, 32'h7FFF_FFFF);
    send(2'd0, 32'h0080_4500, s);
    send(2'd0, 32'h0090_1540, s);
    send(2'd0, 32'h0090_1640, s);
    send(2'd1, 32'h0000_00FF, s);
    chk("R7 clamp high", s, 32'h7FFF_FFFF);
    send(2'd0, 32'h00C0_0200, s);
    chk("R7 clamp low", s, 32'h8000_0000);
    send(2'd1, 32'h0000_0000, s);
    chk("R7 mute", s, 32'd0);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][38:37], VEC[i][36:5], s);
      chk($sformatf("R1 R2 R3 R6 R10 vector %0d", i), s, lvl(int'(VEC[i][4:0])));
    end

    for (int i = 0; i < 16; i++) send(2'd0, {16'h0090, 8'(21 + i), 8'h40}, s);
    chk("R1 sixteen voices", s, lvl(16));
    send(2'd0, 32'h0090_2840, s);
    chk("R1 full pool ignores note-on", s, lvl(16));
    send(2'd0, 32'h0080_2800, s);
    chk("R1 R2 rejected note not held", s, lvl(16));
    send(2'd0, 32'h0080_1700, s);
    chk("R2 release one", s, lvl(15));
    send(2'd0, 32'h0090_3240, s);
    chk("R1 freed voice reused", s, lvl(16));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule